// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block sits between a host register bus and a byte-wide peripheral handshake port. It turns host accesses at two register offsets into peripheral cycles. Offset 3 runs an address cycle and offset 4 runs a data cycle. A cycle only starts when the current control byte permits it. Data accesses may be 1, 2 or 4 bytes wide. A wide access is broken into byte cycles, lowest byte first, and the bytes of a read are put back together in the same order.

The peripheral must answer each byte with a ready within a parameter number of clocks. If it does not, the byte fails, the bytes after it are skipped, and a sticky timeout flag is raised. Software clears the flag by writing the status offset with bit 0 set. A status read returns the flag in bit 0 over the externally supplied status bits.

The host side is valid/ready. `host_ready` is high only when the block is idle. An access is taken in a cycle where `host_valid` and `host_ready` are both high, and `host_ready` then stays low until the single-cycle `rsp_valid` pulse. The response has no back-pressure: the host must take `rsp_rdata` in the pulse cycle. On the peripheral side, `per_valid` stays high with its byte and flags stable until a cycle in which `per_ready` is high, or until the timeout ends the byte. A `per_ready` seen while `per_valid` is low is ignored.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset, `tmo_flag`, `per_valid` and `rsp_valid` are 0 and `host_ready` is 1.
- R2: Offset 3 runs exactly one byte cycle with `per_addr`=1, whatever the size code. Offset 4 runs data cycles with `per_addr`=0.
- R3: A write to offset 3 or 4 runs only when `ctrl_byte & 8'h2F` equals `8'h04`. Otherwise no peripheral cycle occurs and the flag is unchanged.
- R4: A read of offset 3 or 4 runs only when `ctrl_byte & 8'h2F` equals `8'h24`. Otherwise no peripheral cycle occurs and the read returns all ones at the access width (upper bytes 0).
- R5: The size code `host_size` selects 0=1 byte, 1=2 bytes, and 2 or 3=4 bytes. Byte k of `host_wdata` is sent as the k-th byte cycle. The k-th byte read lands in `rsp_rdata[8k+7:8k]`.
- R6: While `per_valid` is high and no `per_ready` has arrived, `per_valid`, `per_wdata`, `per_write` and `per_addr` hold.
- R7: If `per_ready` has not arrived after `TMO_CYCLES` cycles of `per_valid`, the byte fails, `per_valid` drops, and `tmo_flag` is set.
- R8: After a failed byte the remaining bytes are skipped. In a read, the failed and skipped bytes return 8'hFF.
- R9: A read of offset 1 returns `{24'b0, ext_status[7:1], tmo_flag}`. A write of offset 1 with bit 0 set clears the flag; with bit 0 clear it leaves the flag unchanged.
- R10: `host_ready` is low from acceptance until the response. Each access gives exactly one `rsp_valid` pulse. Writes and offsets 0, 2, 5, 6 and 7 return 0, and those offsets run no peripheral cycle.
- R11: Once set, `tmo_flag` stays set through later successful cycles until it is cleared as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Block idle, access accepted |
| host_write | input | 1 | 1 = write, 0 = read |
| host_offset | input | 3 | Register offset |
| host_size | input | 2 | Access width code |
| host_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| ctrl_byte | input | 8 | Current printer control byte |
| ext_status | input | 8 | Printer status bits 7..1 |
| tmo_flag | output | 1 | Sticky timeout flag |
| per_valid | output | 1 | Byte cycle request |
| per_ready | input | 1 | Peripheral completes the byte |
| per_write | output | 1 | 1 = byte write, 0 = byte read |
| per_addr | output | 1 | 1 = address cycle, 0 = data cycle |
| per_wdata | output | 8 | Byte to peripheral |
| per_rdata | input | 8 | Byte from peripheral, taken with per_ready |

## Verification
The embedded properties check on every cycle the following points:
- peripheral request signals hold while waiting;
- the wait counter stays bounded;
- a timeout raises the flag and ends the access at once;
- the flag is sticky;
- host stall covers every peripheral cycle;
- a blocked access never raises a request;
- responses are single pulses.

Only the bench scenarios can show the following:
- the exact control patterns that open the gate;
- little-endian byte order and reassembly;
- all-ones fill on dropped or failed reads;
- status merging;
- the precise cycle count at which a late ready still succeeds.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_DONE} sq_state_t;

  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_ADDR   = 3'd3;
  localparam logic [2:0] OFS_DATA   = 3'd4;

  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WRITE = 8'h04;
  localparam logic [7:0] GATE_READ  = 8'h24;
endpackage

// File: rtl/epp_mode_check.sv
module epp_mode_check
  import epp_pkg::*;
(
  input  logic [7:0] ctrl_byte,
  output logic       wr_ok,
  output logic       rd_ok
);
  logic [7:0] masked;
  assign masked = ctrl_byte & GATE_MASK;
  assign wr_ok  = (masked == GATE_WRITE);
  assign rd_ok  = (masked == GATE_READ);
endmodule

// File: rtl/epp_ready_timer.sv
module epp_ready_timer #(
  parameter int TMO_CYCLES = 8,
  localparam int CW = $clog2(TMO_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ready,
  output logic expire
);
  logic [CW-1:0] cnt_q;

  assign expire = run && !ready && (cnt_q == CW'(TMO_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!run || ready || expire) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  // R7: the wait count never reaches the limit itself
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(TMO_CYCLES));
endmodule

// File: rtl/epp_byte_seq.sv
module epp_byte_seq
  import epp_pkg::*;
#(
  parameter int HOST_BYTES = 4,
  localparam int DW = 8 * HOST_BYTES,
  localparam int IW = (HOST_BYTES > 1) ? $clog2(HOST_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_cycle,
  input  logic          go_imm,
  input  logic          go_write,
  input  logic          go_addr,
  input  logic [IW-1:0] go_last,
  input  logic [DW-1:0] go_wdata,
  input  logic [DW-1:0] imm_rdata,
  input  logic          expire,
  input  logic          per_ready,
  input  logic [7:0]    per_rdata,
  output logic          idle,
  output logic          per_valid,
  output logic          per_write,
  output logic          per_addr,
  output logic [7:0]    per_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  sq_state_t     state_q;
  logic [IW-1:0] idx_q, last_q;
  logic [DW-1:0] wbuf_q, rdata_q, fill;
  logic          write_q, addr_q, hs;

  always_comb begin
    for (int b = 0; b < HOST_BYTES; b++)
      fill[b*8 +: 8] = (IW'(b) <= go_last) ? 8'hFF : 8'h00;
  end

  assign hs = (state_q == SQ_RUN) && per_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      wbuf_q  <= '0;
      rdata_q <= '0;
      write_q <= 1'b0;
      addr_q  <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (go_cycle) begin
            state_q <= SQ_RUN;
            idx_q   <= '0;
            last_q  <= go_last;
            wbuf_q  <= go_wdata;
            write_q <= go_write;
            addr_q  <= go_addr;
            rdata_q <= go_write ? '0 : fill;
          end else if (go_imm) begin
            state_q <= SQ_DONE;
            rdata_q <= imm_rdata;
          end
        end
        SQ_RUN: begin
          if (hs) begin
            if (!write_q) rdata_q[idx_q*8 +: 8] <= per_rdata;
            if (idx_q == last_q) state_q <= SQ_DONE;
            else                 idx_q   <= idx_q + 1'b1;
          end else if (expire) begin
            state_q <= SQ_DONE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign idle      = (state_q == SQ_IDLE);
  assign per_valid = (state_q == SQ_RUN);
  assign per_write = write_q;
  assign per_addr  = addr_q;
  assign per_wdata = wbuf_q[idx_q*8 +: 8];
  assign rsp_valid = (state_q == SQ_DONE);
  assign rsp_rdata = rsp_valid ? rdata_q : '0;

  // R6: request and its byte hold while waiting
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid && !per_ready && !expire |=>
      per_valid && $stable(per_wdata) && $stable(per_write) && $stable(per_addr));

  // R8: a failed byte ends the access at once, skipping the rest
  p_skip_rest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid && expire |=> rsp_valid && !per_valid);

  // R10: the response is a single pulse followed by idle
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && idle);
endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_pkg::*;
#(
  parameter int HOST_BYTES = 4,
  parameter int TMO_CYCLES = 8,
  localparam int DW = 8 * HOST_BYTES,
  localparam int IW = (HOST_BYTES > 1) ? $clog2(HOST_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  output logic          host_ready,
  input  logic          host_write,
  input  logic [2:0]    host_offset,
  input  logic [1:0]    host_size,
  input  logic [DW-1:0] host_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic [7:0]    ctrl_byte,
  input  logic [7:0]    ext_status,
  output logic          tmo_flag,
  output logic          per_valid,
  input  logic          per_ready,
  output logic          per_write,
  output logic          per_addr,
  output logic [7:0]    per_wdata,
  input  logic [7:0]    per_rdata
);
  logic          wr_ok, rd_ok, idle, expire, accept, is_addr, is_data, is_cyc, perm;
  logic          go_cycle, go_imm, clr_req, flag_q, unused_bit0;
  logic [IW-1:0] go_last;
  logic [DW-1:0] fill, imm_rdata;

  assign unused_bit0 = ext_status[0];

  epp_mode_check u_mode (.ctrl_byte(ctrl_byte), .wr_ok(wr_ok), .rd_ok(rd_ok));

  assign is_addr = (host_offset == OFS_ADDR);
  assign is_data = (host_offset == OFS_DATA);
  assign is_cyc  = is_addr || is_data;
  assign perm    = host_write ? wr_ok : rd_ok;
  assign accept  = host_valid && idle;
  assign go_cycle = accept && is_cyc && perm;
  assign go_imm   = accept && !(is_cyc && perm);
  assign clr_req  = accept && host_write && (host_offset == OFS_STATUS) && host_wdata[0];

  always_comb begin
    int n;
    n = 1 << host_size;
    if (n > HOST_BYTES) n = HOST_BYTES;
    go_last = is_data ? IW'(n - 1) : '0;
    for (int b = 0; b < HOST_BYTES; b++)
      fill[b*8 +: 8] = (IW'(b) <= go_last) ? 8'hFF : 8'h00;
    imm_rdata = '0;
    if (!host_write && host_offset == OFS_STATUS)
      imm_rdata[7:0] = {ext_status[7:1], flag_q};
    else if (!host_write && is_cyc)
      imm_rdata = fill;
  end

  epp_ready_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(per_valid), .ready(per_ready), .expire(expire));

  epp_byte_seq #(.HOST_BYTES(HOST_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go_cycle(go_cycle), .go_imm(go_imm), .go_write(host_write), .go_addr(is_addr),
    .go_last(go_last), .go_wdata(host_wdata), .imm_rdata(imm_rdata),
    .expire(expire), .per_ready(per_ready), .per_rdata(per_rdata),
    .idle(idle), .per_valid(per_valid), .per_write(per_write), .per_addr(per_addr),
    .per_wdata(per_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (expire)  flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  assign tmo_flag   = flag_q;
  assign host_ready = idle;

  // R10: host is stalled during every peripheral byte cycle
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid |-> !host_ready);

  // R3: a blocked access never starts a peripheral cycle
  p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_valid && host_ready && is_cyc && !perm |=> !per_valid);

  // R7: a timeout raises the flag
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tmo_flag);

  // R11: the flag only falls on a status write with bit 0 set
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag && !(host_valid && host_ready && host_write &&
                  host_offset == OFS_STATUS && host_wdata[0]) |=> tmo_flag);
endmodule

// File: tb/epp_cycle_gate_tb_top.sv
module epp_cycle_gate_tb_top;
  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [2:0]  host_offset = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic [7:0]  ctrl_byte = '0, ext_status = '0, per_rdata = '0;
  logic        per_ready = 1'b0;
  logic        host_ready, rsp_valid, tmo_flag, per_valid, per_write, per_addr;
  logic [31:0] rsp_rdata;
  logic [7:0]  per_wdata;

  int checks = 0, errors = 0, cyc = 0;
  int lat [4];
  logic [7:0] rbytes [4];
  int acc_base = 0, hs_total = 0, v_total = 0, wait_cnt = 0;
  logic [9:0] log_hs [16];
  logic flag_model = 1'b0;

  always #4 clk = ~clk;

  epp_cycle_gate #(.HOST_BYTES(4), .TMO_CYCLES(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_offset(host_offset), .host_size(host_size),
    .host_wdata(host_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ctrl_byte(ctrl_byte), .ext_status(ext_status), .tmo_flag(tmo_flag),
    .per_valid(per_valid), .per_ready(per_ready), .per_write(per_write),
    .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata));

  // peripheral model: answers byte k after lat[k] waiting cycles
  always @(negedge clk) begin
    per_ready = 1'b0;
    if (per_valid) begin
      int bi;
      v_total++;
      bi = hs_total - acc_base;
      if (bi > 3) bi = 3;
      if (wait_cnt >= lat[bi]) begin
        per_ready = 1'b1;
        per_rdata = rbytes[bi];
        log_hs[hs_total % 16] = {per_write, per_addr, per_wdata};
        hs_total++;
        wait_cnt = 0;
      end else wait_cnt++;
    end else wait_cnt = 0;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic gate_wr(input logic [7:0] c);
    return (c & 8'h2F) == 8'h04;
  endfunction
  function automatic logic gate_rd(input logic [7:0] c);
    return (c & 8'h2F) == 8'h24;
  endfunction

  task automatic run_acc(input logic [7:0] c, input logic w, input logic [2:0] ofs,
                         input logic [1:0] sz, input logic [31:0] wd, input logic [7:0] es);
    int nb, exp_v, exp_hs, hs0, v0, guard;
    logic cyc_ok, is_cyc;
    logic [31:0] erd;
    string rtag;
    nb = (ofs == 3'd4) ? ((sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4) : 1;
    is_cyc = (ofs == 3'd3) || (ofs == 3'd4);
    cyc_ok = is_cyc && (w ? gate_wr(c) : gate_rd(c));
    exp_v = 0; exp_hs = 0; erd = '0; rtag = "R10";
    if (is_cyc && !w) begin
      for (int b = 0; b < nb; b++) erd[b*8 +: 8] = 8'hFF;
      rtag = cyc_ok ? "R5" : "R4";
    end
    if (cyc_ok) begin
      for (int b = 0; b < nb; b++) begin
        if (lat[b] < TMO) begin
          exp_v += lat[b] + 1; exp_hs++;
          if (!w) erd[b*8 +: 8] = rbytes[b];
        end else begin
          exp_v += TMO; flag_model = 1'b1; rtag = "R8";
          break;
        end
      end
    end else if (ofs == 3'd1 && !w) begin
      erd = {24'h0, es[7:1], flag_model}; rtag = "R9";
    end
    @(negedge clk);
    acc_base = hs_total; hs0 = hs_total; v0 = v_total;
    ctrl_byte = c; ext_status = es; host_valid = 1'b1; host_write = w;
    host_offset = ofs; host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_valid = 1'b0;
    chk("R10 stall after accept", {31'b0, host_ready}, 32'd0);
    guard = 0;
    while (!rsp_valid && guard < 200) begin @(negedge clk); guard++; end
    chk(rtag, rsp_rdata, erd);
    if (ofs == 3'd1 && w && wd[0]) flag_model = 1'b0;
    chk("R7/R11 flag", {31'b0, tmo_flag}, {31'b0, flag_model});
    chk(cyc_ok ? "R7 valid cycles" : "R3 no cycle", v_total - v0, exp_v);
    chk("R6 byte count", hs_total - hs0, exp_hs);
    for (int b = 0; b < exp_hs; b++) begin
      logic [9:0] e;
      e = {w, (ofs == 3'd3), w ? wd[b*8 +: 8] : per_wdata_log(hs0 + b)};
      chk("R2/R5 byte order", {22'b0, log_hs[(hs0 + b) % 16]}, {22'b0, e});
    end
    @(negedge clk);
    chk("R10 single pulse", {30'b0, rsp_valid, host_ready}, 32'd1);
  endtask

  function automatic logic [7:0] per_wdata_log(input int i);
    return log_hs[i % 16][7:0];
  endfunction

  task automatic set_lat(input int a, input int b, input int c, input int d);
    lat[0] = a; lat[1] = b; lat[2] = c; lat[3] = d;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    set_lat(0, 0, 0, 0);
    for (int i = 0; i < 4; i++) rbytes[i] = 8'(8'h11 * (i + 1));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'b0, tmo_flag, per_valid, rsp_valid, host_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_acc(8'h04, 1'b1, 3'd4, 2'd2, 32'hA1B2C3D4, 8'hF0);   // R5 four-byte write
    run_acc(8'hC4, 1'b1, 3'd3, 2'd2, 32'h00000055, 8'h00);   // R2 address write, size ignored
    run_acc(8'h24, 1'b0, 3'd4, 2'd1, 32'h0, 8'h00);          // R5 two-byte read
    run_acc(8'h0C, 1'b1, 3'd4, 2'd0, 32'h77, 8'h00);         // R3 dropped write
    run_acc(8'h04, 1'b0, 3'd4, 2'd2, 32'h0, 8'h00);          // R4 dropped wide read
    run_acc(8'h24, 1'b0, 3'd3, 2'd0, 32'h0, 8'h00);          // R2 address read
    set_lat(TMO - 1, 0, 0, 0);
    run_acc(8'h24, 1'b0, 3'd4, 2'd0, 32'h0, 8'h00);          // R7 last-chance ready
    set_lat(0, 1, TMO, 0);
    run_acc(8'h24, 1'b0, 3'd4, 2'd2, 32'h0, 8'h00);          // R8 fail at byte 2
    set_lat(0, 0, 0, 0);
    run_acc(8'h04, 1'b1, 3'd4, 2'd3, 32'h01020304, 8'h00);   // R11 flag stays
    run_acc(8'h00, 1'b0, 3'd1, 2'd0, 32'h0, 8'hA5);          // R9 status read
    run_acc(8'h00, 1'b1, 3'd1, 2'd0, 32'hFE, 8'h00);         // R9 bit0 clear: no effect
    run_acc(8'h00, 1'b1, 3'd1, 2'd0, 32'h01, 8'h00);         // R9 clear
    run_acc(8'h04, 1'b0, 3'd6, 2'd0, 32'h0, 8'h00);          // R10 other offset
    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [7:0] c;
      logic [2:0] o;
      int pick;
      pick = $urandom % 3;
      c = 8'($urandom) & 8'hD0;
      if (pick == 0) c = c | 8'h04;
      else if (pick == 1) c = c | 8'h24;
      else c = 8'($urandom);
      pick = $urandom % 8;
      o = (pick < 3) ? 3'd4 : (pick < 5) ? 3'd3 : (pick == 5) ? 3'd1 : 3'($urandom);
      for (int b = 0; b < 4; b++) begin
        lat[b] = (($urandom % 10) == 0) ? TMO + int'($urandom % 3) - 1 : int'($urandom % 4);
        rbytes[b] = 8'($urandom);
      end
      run_acc(c, 1'($urandom), o, 2'($urandom), $urandom, 8'($urandom));
    end
    summary();
  end
endmodule